// File: doc/BRIEF.md
# Receive Event Interrupt Collector

This block gathers the event and condition signals of a digital audio link into one status word and drives one interrupt request line. Four receive events arrive from the line decoder as one-cycle pulses: a bad or missing preamble, a block-start (B) preamble, a completed channel-status block, and a valid user-data information unit. Each event latches into a sticky bit. The bit stays set until software writes a 1 to its position. Beside these bits the status word reports four FIFO attention conditions and two FIFO error conditions. Those six bits follow their input levels, registered for one cycle.

Each of the ten status bits has its own interrupt enable bit in a second register. The interrupt output is a registered OR of every status bit whose enable is set. Software reaches both registers through a simple single-cycle bus. A write takes effect at the clock edge where it is presented. Read data appears one cycle after the request and then holds until the next read.

Status and enable bit layout (identical in both registers):

- Bit 0: preamble error
- Bit 1: B preamble
- Bit 2: channel-status block
- Bit 3: user unit
- Bits 4 to 7: attention for receive user, transmit user, receive data and transmit data
- Bit 8: transmit error
- Bit 9: receive error

Top module: `rx_event_irq`

## Requirements
- R1: After reset, the interrupt output is 0, both registers read 0 while all level inputs are 0, and the read data output is 0.
- R2: A pulse on `evt_pulse[i]` (i = 0..3) sets status bit i at that clock edge. A sticky bit never rises without a pulse.
- R3: A set sticky bit stays set on later cycles until a clearing write reaches it.
- R4: A write to the status register (address 0) clears each sticky bit whose data bit is 1. Sticky bits whose data bit is 0 keep their value.
- R5: When an event pulse and a clearing write hit the same sticky bit in one cycle, the bit ends set.
- R6: Status bits 4..7 equal `attn_lvl[3:0]` and bits 8..9 equal `err_lvl[1:0]`, each as sampled one cycle earlier. Writes to the status register do not change them.
- R7: `irq` is 1 in a cycle exactly when, one cycle earlier, at least one status bit had its enable bit (same position, address 1) set. A disabled source never raises `irq`.
- R8: After a write clears the last enabled pending sticky bit, `irq` stays 1 for the cycle following that write edge and reads 0 one cycle later.
- R9: The enable register (address 1) stores write-data bits 9..0. Its bits above 9 read as 0.
- R10: A read (sel=1, wr=0) puts the addressed register onto `bus_rdata` at the next edge, using the value from before that edge. Addresses 2 and 3 read 0. `bus_rdata` holds its value when no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 4 | One-cycle event pulses: preamble error, B preamble, channel-status block, user unit |
| attn_lvl | input | 4 | FIFO attention levels: rx user, tx user, rx data, tx data |
| err_lvl | input | 2 | FIFO error levels: bit 0 transmit, bit 1 receive |
| bus_sel | input | 1 | Bus access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (2) | Register address: 0 status, 1 enable |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions check on every cycle that a pulse sets its sticky bit, that a sticky bit neither rises without a pulse nor falls without a clearing write, that a clearing write without a coincident pulse drops the bit, that the level bits track their inputs with one cycle of delay, and that the interrupt follows the enabled sources one cycle later. Other behaviours only show through the bench's scenarios:

- the read path, including the read latency, the zero read of unused addresses and the hold of read data between reads;
- the truncation of the enable register;
- the event-beats-clear race observed through a bus read;
- the exact cycle at which the interrupt drops after the final clear.

A long random run compares the interrupt and the read data against a model written in the bench.

// File: rtl/rx_event_pkg.sv
package rx_event_pkg;
  // Source counts
  localparam int STICKY_N = 4;
  localparam int ATTN_N   = 4;
  localparam int ERR_N    = 2;
  localparam int SRC_N    = STICKY_N + ATTN_N + ERR_N;
  // Field positions inside the status and enable words
  localparam int ATTN_LSB = STICKY_N;
  localparam int ERR_LSB  = STICKY_N + ATTN_N;
  // Register addresses
  localparam int ADDR_STATUS = 0;
  localparam int ADDR_ENABLE = 1;

  typedef logic [SRC_N-1:0] src_vec_t;
endpackage

// File: rtl/rx_event_sticky.sv
module rx_event_sticky #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        q_o[i] <= 1'b0;
      else if (set_i[i])
        q_o[i] <= 1'b1;        // event beats a same-cycle clear
      else if (clr_i[i])
        q_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_event_level_reg.sv
module rx_event_level_reg #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= d_i;
  end
endmodule

// File: rtl/rx_event_irq_gate.sv
module rx_event_irq_gate #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  logic any_pending;

  always_comb any_pending = |(src_i & en_i);

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= any_pending;
  end
endmodule

// File: rtl/rx_event_regport.sv
module rx_event_regport
  import rx_event_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  src_vec_t            status_i,
  output src_vec_t            enable_o,
  output logic [STICKY_N-1:0] clr_o,
  output logic [DATA_W-1:0]   bus_rdata
);
  logic hit_status, hit_enable, do_write, do_read;
  logic [DATA_W-1:0] rd_next;
  logic unused_wdata;

  always_comb begin
    hit_status = (bus_addr == ADDR_W'(ADDR_STATUS));
    hit_enable = (bus_addr == ADDR_W'(ADDR_ENABLE));
    do_write   = bus_sel && bus_wr;
    do_read    = bus_sel && !bus_wr;
    clr_o      = (do_write && hit_status) ? bus_wdata[STICKY_N-1:0] : '0;
  end

  assign unused_wdata = ^bus_wdata[DATA_W-1:SRC_N];

  always_ff @(posedge clk) begin
    if (rst)
      enable_o <= '0;
    else if (do_write && hit_enable)
      enable_o <= bus_wdata[SRC_N-1:0];
  end

  always_comb begin
    if (hit_status)      rd_next = DATA_W'(status_i);
    else if (hit_enable) rd_next = DATA_W'(enable_o);
    else                 rd_next = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)          bus_rdata <= '0;
    else if (do_read) bus_rdata <= rd_next;
  end
endmodule

// File: rtl/rx_event_irq.sv
module rx_event_irq
  import rx_event_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [STICKY_N-1:0] evt_pulse,
  input  logic [ATTN_N-1:0]   attn_lvl,
  input  logic [ERR_N-1:0]    err_lvl,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                irq
);
  localparam int LVL_N = ATTN_N + ERR_N;

  logic [STICKY_N-1:0] sticky_q;
  logic [STICKY_N-1:0] clr_mask;
  logic [LVL_N-1:0]    level_q;
  src_vec_t            status_w;
  src_vec_t            enable_q;

  rx_event_sticky #(.N(STICKY_N)) u_sticky (
    .clk(clk), .rst(rst), .set_i(evt_pulse), .clr_i(clr_mask), .q_o(sticky_q)
  );

  rx_event_level_reg #(.N(LVL_N)) u_level (
    .clk(clk), .rst(rst), .d_i({err_lvl, attn_lvl}), .q_o(level_q)
  );

  assign status_w = {level_q, sticky_q};

  rx_event_regport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .status_i(status_w),
    .enable_o(enable_q), .clr_o(clr_mask), .bus_rdata(bus_rdata)
  );

  rx_event_irq_gate #(.N(SRC_N)) u_gate (
    .clk(clk), .rst(rst), .src_i(status_w), .en_i(enable_q), .irq_o(irq)
  );
endmodule

// File: rtl/rx_event_checker.sv
module rx_event_checker
  import rx_event_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input logic                      clk,
  input logic                      rst,
  input logic [STICKY_N-1:0]       evt_pulse,
  input logic [ATTN_N-1:0]         attn_lvl,
  input logic [ERR_N-1:0]          err_lvl,
  input logic                      bus_sel,
  input logic                      bus_wr,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic [DATA_W-1:0]         bus_wdata,
  input logic                      irq,
  input logic [STICKY_N-1:0]       stk,
  input logic [ATTN_N+ERR_N-1:0]   lvl,
  input logic [SRC_N-1:0]          en
);
  logic wr_status;
  assign wr_status = bus_sel && bus_wr && (bus_addr == ADDR_W'(ADDR_STATUS));

  for (genvar i = 0; i < STICKY_N; i++) begin : g_chk
    assert_event_sets_R2: assert property (@(posedge clk) disable iff (rst)
      evt_pulse[i] |=> stk[i]);
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
      !evt_pulse[i] |=> !$rose(stk[i]));
    assert_sticky_holds_R3: assert property (@(posedge clk) disable iff (rst)
      (stk[i] && !(wr_status && bus_wdata[i])) |=> stk[i]);
    assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (rst)
      (wr_status && bus_wdata[i] && !evt_pulse[i]) |=> !stk[i]);
  end

  assert_level_follow_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (lvl == $past({err_lvl, attn_lvl})));
  assert_irq_rise_R7: assert property (@(posedge clk) disable iff (rst)
    (|({lvl, stk} & en)) |=> irq);
  assert_irq_fall_R7: assert property (@(posedge clk) disable iff (rst)
    !(|({lvl, stk} & en)) |=> !irq);
endmodule

bind rx_event_irq rx_event_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .attn_lvl(attn_lvl),
  .err_lvl(err_lvl), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq(irq), .stk(sticky_q), .lvl(level_q), .en(enable_q)
);

// File: tb/rx_event_irq_bench.sv
module rx_event_irq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RAND_CYCLES = 4000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  evt_pulse = '0;
  logic [3:0]  attn_lvl = '0;
  logic [1:0]  err_lvl = '0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_event_irq u_rx_event_irq (
    .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .attn_lvl(attn_lvl),
    .err_lvl(err_lvl), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic do_write(logic [1:0] a, logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic do_read(logic [1:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(logic [3:0] e);
    evt_pulse = e;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  // Reference model helpers
  function automatic logic [3:0] next_sticky(logic [3:0] s, logic [3:0] e, logic clr_en,
                                             logic [3:0] mask);
    return e | (s & ~(clr_en ? mask : 4'h0));
  endfunction

  function automatic logic [31:0] read_mux(logic [1:0] a, logic [9:0] st, logic [9:0] en);
    case (a)
      2'd0:    return {22'd0, st};
      2'd1:    return {22'd0, en};
      default: return 32'd0;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();

    // R1: reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 rdata", bus_rdata, 32'd0);
    do_read(2'd0, rd); chk("R1 status", rd, 32'd0);
    do_read(2'd1, rd); chk("R1 enable", rd, 32'd0);

    // R2 / R3: event sets the sticky bit and it holds
    pulse(4'b0100);
    do_read(2'd0, rd); chk("R2 set bit2", rd, 32'h004);
    repeat (5) @(negedge clk);
    do_read(2'd0, rd); chk("R3 hold", rd, 32'h004);

    // R4: write 0 keeps the bit, write 1 clears it
    pulse(4'b1001);
    do_write(2'd0, 32'h0);
    do_read(2'd0, rd); chk("R4 write0 keeps", rd, 32'h00D);
    do_write(2'd0, 32'h004);
    do_read(2'd0, rd); chk("R4 partial clear", rd, 32'h009);
    do_write(2'd0, 32'hF);
    do_read(2'd0, rd); chk("R4 clear all", rd, 32'h000);

    // R5: event and clear on the same bit in one cycle
    evt_pulse = 4'b0010;
    do_write(2'd0, 32'h002);
    evt_pulse = '0;
    do_read(2'd0, rd); chk("R5 event wins", rd, 32'h002);
    do_write(2'd0, 32'h002);

    // R6: level bits follow inputs and ignore writes
    attn_lvl = 4'b1010; err_lvl = 2'b01;
    repeat (2) @(negedge clk);
    do_read(2'd0, rd); chk("R6 levels", rd, 32'h1A0);
    do_write(2'd0, 32'h3F0);
    do_read(2'd0, rd); chk("R6 write ignored", rd, 32'h1A0);
    attn_lvl = '0; err_lvl = '0;
    repeat (2) @(negedge clk);
    do_read(2'd0, rd); chk("R6 levels drop", rd, 32'h000);

    // R9: enable truncation
    do_write(2'd1, 32'hFFFF_FFFF);
    do_read(2'd1, rd); chk("R9 enable width", rd, 32'h3FF);

    // R7: disabled source does not raise irq; enabling it does
    do_write(2'd1, 32'h0);
    pulse(4'b0001);
    repeat (2) @(negedge clk);
    chk("R7 disabled", {31'd0, irq}, 32'd0);
    do_write(2'd1, 32'h001);
    @(negedge clk);
    chk("R7 enabled", {31'd0, irq}, 32'd1);

    // R8: irq drops one cycle after the clearing write edge
    do_write(2'd0, 32'h001);
    chk("R8 still high", {31'd0, irq}, 32'd1);
    @(negedge clk);
    chk("R8 low", {31'd0, irq}, 32'd0);

    // R7: attention level as an interrupt source
    do_write(2'd1, 32'h020);
    attn_lvl = 4'b0010;
    repeat (3) @(negedge clk);
    chk("R7 attn irq", {31'd0, irq}, 32'd1);
    attn_lvl = 4'b0000;
    repeat (3) @(negedge clk);
    chk("R7 attn irq off", {31'd0, irq}, 32'd0);

    // R10: unused address reads 0; rdata holds between reads
    do_read(2'd1, rd); chk("R10 enable read", rd, 32'h020);
    repeat (3) @(negedge clk);
    chk("R10 hold", bus_rdata, 32'h020);
    do_read(2'd3, rd); chk("R10 unused addr", rd, 32'h0);

    // Random phase against the model
    do_reset();
    begin
      logic [3:0] m_stk = '0;
      logic [5:0] m_lvl = '0;
      logic [9:0] m_en = '0;
      logic       m_irq = 1'b0;
      logic [31:0] m_rd = '0;
      for (int c = 0; c < RAND_CYCLES; c++) begin
        logic [3:0] n_stk;
        logic       wst, wen;
        evt_pulse = 4'($urandom & $urandom & $urandom);
        if (($urandom % 8) == 0) attn_lvl = 4'($urandom);
        if (($urandom % 16) == 0) err_lvl = 2'($urandom);
        bus_sel   = (($urandom % 3) == 0);
        bus_wr    = 1'($urandom);
        bus_addr  = 2'($urandom);
        bus_wdata = $urandom;
        wst = bus_sel && bus_wr && bus_addr == 2'd0;
        wen = bus_sel && bus_wr && bus_addr == 2'd1;
        n_stk = next_sticky(m_stk, evt_pulse, wst, bus_wdata[3:0]);
        if (bus_sel && !bus_wr) m_rd = read_mux(bus_addr, {m_lvl, m_stk}, m_en);
        m_irq = |({m_lvl, m_stk} & m_en);
        m_stk = n_stk;
        m_lvl = {err_lvl, attn_lvl};
        if (wen) m_en = bus_wdata[9:0];
        @(negedge clk);
        chk("R7 random irq", {31'd0, irq}, {31'd0, m_irq});
        chk("R10 random rdata", bus_rdata, m_rd);
      end
      evt_pulse = '0; bus_sel = 1'b0;
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule